// File: doc/BRIEF.md
# Bus Lock Ownership Tracker

This block follows the exclusive-access lock on a parallel shared bus that uses active-low framing and lock signals. It watches the frame strobe, the lock strobe, the address and the identity of the master currently on the bus. From these it works out whether a lock is held, which master owns it, and which 16-byte region it covers. A locked sequence may stretch over many separate bus transactions. Being granted the bus is not enough to take the lock: a master takes it only by following the lock handshake during one of its own transactions.

For every new transaction the tracker gives a one-cycle verdict. A pass verdict lets a target assert its ready strobe. A retry verdict tells the target to stop the transaction without ever asserting ready. When the lock is held in the normal mode, only accesses by other masters to the locked region are refused, and all other traffic keeps flowing. When the system-lock input is set, every master except the owner is refused. The tracker also drives a grant mask, so that an arbiter can keep those other masters off the bus until the lock strobe goes away.

Top module: `lkt_lock_tracker`

## Requirements
- R1: After reset no lock is held, the stored region and owner are zero, neither verdict pulse is active, and every bit of `gnt_mask` is 1.
- R2: An address phase is a clock edge where `frame_n` is sampled low after being sampled high at the previous edge. Exactly one of `xact_pass` or `xact_retry` is high for the single cycle that follows each address phase. Both are low in every other cycle.
- R3: A lock is taken when all of these hold: no lock is held, `lock_n` is sampled high in an address phase, and `lock_n` is sampled low at the next edge. At that next edge `lock_held` becomes 1 and `lock_owner` takes the `mst_id` of the address phase.
- R4: The locked region is `addr[AW-1:4]` of the address phase that took the lock. Region comparisons ignore `addr[3:0]`.
- R5: While a lock is held in normal mode, an address phase from a master other than the owner, to the locked region, gets `xact_retry`.
- R6: While a lock is held in normal mode, an address phase from a non-owner to any other region gets `xact_pass`.
- R7: An address phase from the lock owner always gets `xact_pass`.
- R8: With `sys_lock_mode` high and a lock held, every non-owner address phase gets `xact_retry`, and `gnt_mask` is one-hot with only bit `lock_owner` set. In all other cases `gnt_mask` is all ones. Bit i of `gnt_mask` belongs to master i.
- R9: A held lock is released at the first edge where `frame_n` and `lock_n` are both sampled high. The stored region and owner keep their values after release.
- R10: A transaction whose `lock_n` is already low during its address phase does not take a free lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_lock_mode | input | 1 | 1 = full system lock, 0 = region lock |
| frame_n | input | 1 | Active-low frame strobe |
| lock_n | input | 1 | Active-low lock strobe |
| addr | input | AW | Bus address, valid in the address phase |
| mst_id | input | IDW | Index of the master that owns the current transaction |
| xact_pass | output | 1 | One-cycle pulse: the transaction may complete |
| xact_retry | output | 1 | One-cycle pulse: stop the transaction without ready |
| lock_held | output | 1 | A lock is currently held |
| lock_region | output | AW-4 | Locked region, address bits AW-1 down to 4 |
| lock_owner | output | IDW | Index of the master that holds the lock |
| gnt_mask | output | NM | Per-master grant permission for the arbiter |

## Verification
The bench goes after four corner cases.

- **Low address bits in the region compare.** Non-owner accesses use addresses inside the locked 16-byte region but with nonzero low bits. A design that compared the low bits would pass these accesses instead of retrying them.
- **Lock strobe already low.** Some transactions start with `lock_n` already low. A tracker that keyed only on a low `lock_n` would take a lock it was never handed.
- **Release condition.** Some cycles have a high frame strobe while `lock_n` is still held low. A design that released on the frame strobe alone would drop the lock too early.
- **System-lock mode.** The mode is switched while a lock is held. A design that ignored the mode would pass other masters outside the region, or leave their bits set in the grant mask.

// File: rtl/lkt_pkg.sv
package lkt_pkg;
  // Outcome of one address phase, held for a single cycle
  typedef enum logic [1:0] {
    VRD_IDLE  = 2'd0,
    VRD_PASS  = 2'd1,
    VRD_RETRY = 2'd2
  } verdict_e;
endpackage

// File: rtl/lkt_phase_det.sv
module lkt_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  output logic addr_phase
);
  logic frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  // first cycle of a frame: strobe low now, high one edge earlier
  assign addr_phase = !frame_n && frame_q;
endmodule

// File: rtl/lkt_lock_state.sv
module lkt_lock_state #(
  parameter int RW  = 28,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           addr_phase,
  input  logic           frame_n,
  input  logic           lock_n,
  input  logic [RW-1:0]  rgn_in,
  input  logic [IDW-1:0] id_in,
  output logic           locked,
  output logic [RW-1:0]  region,
  output logic [IDW-1:0] owner,
  output logic           acquire,
  output logic           release_ev
);
  logic           pend;
  logic [RW-1:0]  pend_rgn;
  logic [IDW-1:0] pend_id;

  assign acquire    = pend && !lock_n && !locked;
  assign release_ev = locked && frame_n && lock_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_rgn <= '0;
      pend_id  <= '0;
      locked   <= 1'b0;
      region   <= '0;
      owner    <= '0;
    end else begin
      // an attempt opens only when lock strobe is idle in the address phase
      pend <= addr_phase && lock_n && !locked;
      if (addr_phase) begin
        pend_rgn <= rgn_in;
        pend_id  <= id_in;
      end
      if (release_ev) begin
        locked <= 1'b0;
      end else if (acquire) begin
        locked <= 1'b1;
        region <= pend_rgn;
        owner  <= pend_id;
      end
    end
  end
endmodule

// File: rtl/lkt_verdict.sv
module lkt_verdict #(
  parameter int RW  = 28,
  parameter int IDW = 2,
  parameter int NM  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           addr_phase,
  input  logic           sys_mode,
  input  logic           locked,
  input  logic [RW-1:0]  region,
  input  logic [IDW-1:0] owner,
  input  logic [RW-1:0]  rgn_in,
  input  logic [IDW-1:0] id_in,
  output logic           xact_pass,
  output logic           xact_retry,
  output logic [NM-1:0]  gnt_mask
);
  import lkt_pkg::*;

  function automatic logic must_refuse(input logic lk, input logic sys,
                                       input logic same_rgn, input logic is_owner);
    return lk && !is_owner && (sys || same_rgn);
  endfunction

  verdict_e vrd_q;
  logic     refuse_now;

  assign refuse_now = must_refuse(locked, sys_mode, rgn_in == region, id_in == owner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vrd_q <= VRD_IDLE;
    else if (!addr_phase) vrd_q <= VRD_IDLE;
    else if (refuse_now) vrd_q <= VRD_RETRY;
    else                 vrd_q <= VRD_PASS;
  end

  assign xact_pass  = (vrd_q == VRD_PASS);
  assign xact_retry = (vrd_q == VRD_RETRY);

  for (genvar g = 0; g < NM; g++) begin : g_mask
    assign gnt_mask[g] = !(sys_mode && locked) || (owner == IDW'(g));
  end
endmodule

// File: rtl/lkt_lock_tracker.sv
module lkt_lock_tracker #(
  parameter int AW   = 32,
  parameter int NM   = 4,
  parameter int GRAN = 4,
  localparam int RW  = AW - GRAN,
  localparam int IDW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sys_lock_mode,
  input  logic           frame_n,
  input  logic           lock_n,
  input  logic [AW-1:0]  addr,
  input  logic [IDW-1:0] mst_id,
  output logic           xact_pass,
  output logic           xact_retry,
  output logic           lock_held,
  output logic [RW-1:0]  lock_region,
  output logic [IDW-1:0] lock_owner,
  output logic [NM-1:0]  gnt_mask
);
  logic          addr_phase_w;
  logic          acquire_w;
  logic          release_w;
  logic [RW-1:0] addr_rgn;

  // 16-byte granule: drop the low bits
  assign addr_rgn = RW'(addr >> GRAN);

  lkt_phase_det u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .addr_phase (addr_phase_w)
  );

  lkt_lock_state #(.RW(RW), .IDW(IDW)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase_w),
    .frame_n    (frame_n),
    .lock_n     (lock_n),
    .rgn_in     (addr_rgn),
    .id_in      (mst_id),
    .locked     (lock_held),
    .region     (lock_region),
    .owner      (lock_owner),
    .acquire    (acquire_w),
    .release_ev (release_w)
  );

  lkt_verdict #(.RW(RW), .IDW(IDW), .NM(NM)) u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase_w),
    .sys_mode   (sys_lock_mode),
    .locked     (lock_held),
    .region     (lock_region),
    .owner      (lock_owner),
    .rgn_in     (addr_rgn),
    .id_in      (mst_id),
    .xact_pass  (xact_pass),
    .xact_retry (xact_retry),
    .gnt_mask   (gnt_mask)
  );
endmodule

// File: rtl/lkt_chk.sv
module lkt_chk #(
  parameter int AW   = 32,
  parameter int NM   = 4,
  parameter int GRAN = 4,
  parameter int RW   = 28,
  parameter int IDW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sys_lock_mode,
  input logic           frame_n,
  input logic           lock_n,
  input logic [AW-1:0]  addr,
  input logic [IDW-1:0] mst_id,
  input logic           xact_pass,
  input logic           xact_retry,
  input logic           lock_held,
  input logic [RW-1:0]  lock_region,
  input logic [IDW-1:0] lock_owner,
  input logic [NM-1:0]  gnt_mask,
  input logic           addr_phase
);
  // R2
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> (xact_pass ^ xact_retry));

  // R2
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xact_pass, xact_retry}));

  // R5
  region_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && lock_held && (mst_id != lock_owner) &&
    ((addr >> GRAN) == AW'(lock_region)) |=> xact_retry);

  // R7
  owner_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && lock_held && (mst_id == lock_owner) |=> xact_pass);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_held && frame_n && lock_n |=> !lock_held);

  // R3
  acquire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_held) |-> ($past(!lock_n) && $past(addr_phase, 2)));

  // R8
  sys_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_lock_mode && lock_held |-> (gnt_mask == (NM'(1) << lock_owner)));

  // R1
  free_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_held |-> (&gnt_mask));
endmodule

bind lkt_lock_tracker lkt_chk #(
  .AW(AW), .NM(NM), .GRAN(GRAN), .RW(RW), .IDW(IDW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sys_lock_mode (sys_lock_mode),
  .frame_n       (frame_n),
  .lock_n        (lock_n),
  .addr          (addr),
  .mst_id        (mst_id),
  .xact_pass     (xact_pass),
  .xact_retry    (xact_retry),
  .lock_held     (lock_held),
  .lock_region   (lock_region),
  .lock_owner    (lock_owner),
  .gnt_mask      (gnt_mask),
  .addr_phase    (addr_phase_w)
);

// File: tb/tb_lkt_lock_tracker.sv
`timescale 1ns/1ps
module tb_lkt_lock_tracker;
  localparam int AW = 32, NM = 4, GRAN = 4, RW = AW - GRAN, IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0, sys_lock_mode = 1'b0, frame_n = 1'b1, lock_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [IDW-1:0] mst_id = '0;
  logic xact_pass, xact_retry, lock_held;
  logic [RW-1:0] lock_region;
  logic [IDW-1:0] lock_owner;
  logic [NM-1:0] gnt_mask;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  lkt_lock_tracker #(.AW(AW), .NM(NM), .GRAN(GRAN)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NM-1:0] exp_mask(input logic sys, input logic lk, input logic [IDW-1:0] own);
    logic [NM-1:0] m;
    m = '1;
    if (sys && lk) begin
      m = '0;
      m[own] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [RW-1:0] granule(input logic [AW-1:0] a);
    return a[AW-1:GRAN];
  endfunction

  // reference state, stepped at each rising edge
  logic m_fq, m_lock, m_pend, m_pass, m_retry, m_rel;
  logic [RW-1:0] m_reg, m_preg;
  logic [IDW-1:0] m_own, m_pid;

  always @(posedge clk) begin
    logic ap, refuse, old_lock;
    if (!rst_n) begin
      m_fq = 1; m_lock = 0; m_pend = 0; m_pass = 0; m_retry = 0; m_rel = 0;
      m_reg = '0; m_preg = '0; m_own = '0; m_pid = '0;
    end else begin
      ap = !frame_n && m_fq;
      old_lock = m_lock;
      refuse = ap && m_lock && (mst_id != m_own) &&
               (sys_lock_mode || granule(addr) == m_reg);
      m_pass = ap && !refuse;
      m_retry = refuse;
      m_rel = 0;
      if (m_lock && frame_n && lock_n) begin
        m_lock = 0; m_rel = 1;
      end else if (!m_lock && m_pend && !lock_n) begin
        m_lock = 1; m_reg = m_preg; m_own = m_pid;
      end
      m_pend = ap && lock_n && !old_lock;
      if (ap) begin
        m_preg = granule(addr); m_pid = mst_id;
      end
      m_fq = frame_n;
    end
  end

  always @(negedge clk) begin
    string tag;
    if (rst_n && cmp_en) begin
      chk((xact_pass | xact_retry) == (m_pass | m_retry), "R2", xact_pass | xact_retry, m_pass | m_retry);
      if (m_retry) tag = sys_lock_mode ? "R8" : "R5";
      else if (m_pass && mst_id == m_own && m_lock) tag = "R7";
      else tag = "R6";
      chk(xact_retry == m_retry && xact_pass == m_pass, tag, {xact_pass, xact_retry}, {m_pass, m_retry});
      chk(lock_held == m_lock, m_rel ? "R9" : "R3", lock_held, m_lock);
      chk(lock_region == m_reg, "R4", lock_region, m_reg);
      chk(lock_owner == m_own, "R3", lock_owner, m_own);
      chk(gnt_mask == exp_mask(sys_lock_mode, m_lock, m_own), "R8", gnt_mask, exp_mask(sys_lock_mode, m_lock, m_own));
    end
  end

  task automatic step(input logic f, input logic l, input logic [AW-1:0] a, input logic [IDW-1:0] id);
    frame_n = f; lock_n = l; addr = a; mst_id = id;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!lock_held && lock_region == 0 && lock_owner == 0, "R1", lock_held, 0);
    chk(!xact_pass && !xact_retry, "R1", {xact_pass, xact_retry}, 0);
    chk(gnt_mask == '1, "R1", gnt_mask, 4'hF);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // directed: take lock at 0x1004 by master 1
    step(1, 1, 32'h0, 0);
    step(0, 1, 32'h1004, 1);
    chk(xact_pass, "R2", xact_pass, 1);
    step(0, 0, 32'h1004, 1);
    chk(lock_held && lock_owner == 1, "R3", {lock_held, lock_owner}, 3'b101);
    chk(lock_region == 28'h100, "R4", lock_region, 28'h100);
    step(1, 0, 32'h0, 0);
    chk(lock_held, "R9", lock_held, 1);              // frame high alone keeps lock
    step(0, 0, 32'h100C, 2);
    chk(xact_retry, "R5", xact_retry, 1);            // low bits differ, same granule
    step(1, 0, 32'h0, 0);
    step(0, 0, 32'h2000, 2);
    chk(xact_pass, "R6", xact_pass, 1);
    step(1, 0, 32'h0, 0);
    step(0, 0, 32'h1008, 1);
    chk(xact_pass, "R7", xact_pass, 1);
    sys_lock_mode = 1'b1;
    step(1, 0, 32'h0, 0);
    chk(gnt_mask == 4'b0010, "R8", gnt_mask, 4'b0010);
    step(0, 0, 32'h2000, 2);
    chk(xact_retry, "R8", xact_retry, 1);
    sys_lock_mode = 1'b0;
    step(1, 1, 32'h0, 0);
    chk(!lock_held, "R9", lock_held, 0);
    // R10: lock strobe already low at address phase
    step(1, 1, 32'h0, 0);
    step(0, 0, 32'h3000, 3);
    step(0, 0, 32'h3000, 3);
    chk(!lock_held, "R10", lock_held, 0);
    step(1, 0, 32'h0, 0);
    chk(!lock_held, "R10", lock_held, 0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      case ($urandom % 4)
        0: a = 32'h1000 | ($urandom % 16);
        1: a = 32'h1010 | ($urandom % 16);
        2: a = 32'h2000 | ($urandom % 16);
        default: a = $urandom;
      endcase
      if (i % 500 == 0) sys_lock_mode = ~sys_lock_mode;
      step(($urandom % 3) == 0, ($urandom % 3) != 0, a, IDW'($urandom % NM));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule